// File: doc/BRIEF.md
# Dual-Channel Serial Code Loader

This block takes a 24-bit serial frame that holds two 12-bit converter codes and keeps each code in its own holding register for an analog stage to use. A host drives a serial clock, a data line, an active-low select and two active-low update strobes. Every pin is sampled by the system clock through a synchronizer. All edges are recognised in that clock domain, so everything the block does is synchronous except the clear.

Each serial-clock falling edge moves one data bit into the frame register, provided select is low and both strobes are high. After a full frame, a falling edge on one strobe copies that channel's field into its holding register. Both strobes falling together update both channels in the same cycle. An active-low clear empties the frame register and both holding registers at once, without waiting for a clock edge.

The pins are plain levels. There is no flow control, because the host paces every transfer with its own edges.

Top module: `dual_code_loader`

## Requirements
- R1: While `clr_n` is low, `code_a_o`, `code_b_o` and the frame register are all zero. They clear as soon as `clr_n` falls, without a clock edge, and clear wins over any shift or load pending in that cycle.
- R2: The frame register moves only on a falling edge of `sclk_i`, and only when `sel_n_i` is low and both `upd_a_n_i` and `upd_b_n_i` are high. Rising edges never shift, and neither does a falling edge while either strobe is low.
- R3: A shift places `sdi_i` at frame position 23 and moves every other bit one place toward position 0. Sending the 24-bit word {B code, A code} MSB first therefore puts the A code at positions 12..23 (MSB at 12) and the B code at positions 0..11 (MSB at 0).
- R4: A falling edge on `upd_a_n_i` with `sel_n_i` low loads channel A: bit i of `code_a_o` is frame bit 23-i. `code_b_o` is unchanged.
- R5: A falling edge on `upd_b_n_i` with `sel_n_i` low loads channel B: bit i of `code_b_o` is frame bit 11-i. `code_a_o` is unchanged.
- R6: When both strobes fall in the same sampled cycle with `sel_n_i` low, both channels load in that cycle.
- R7: While `sel_n_i` is high, serial-clock edges and strobe edges change neither the frame register nor either code.
- R8: A load happens once per strobe falling edge. A strobe that falls while `sel_n_i` is high does not load when `sel_n_i` later goes low with the strobe still held low.
- R9: A pin change driven before clock edge p takes effect at edge p+SYNC_STAGES. It enters the sampler at edge p and needs SYNC_STAGES-1 further edges to reach the edge detector.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to sample all pins |
| clr_n | input | 1 | Asynchronous active-low clear |
| sclk_i | input | 1 | Serial clock; bits are taken on its falling edge |
| sdi_i | input | 1 | Serial data, MSB first |
| sel_n_i | input | 1 | Active-low select; gates both shifting and loading |
| upd_a_n_i | input | 1 | Active-low update strobe for channel A |
| upd_b_n_i | input | 1 | Active-low update strobe for channel B |
| code_a_o | output | CODE_W | Channel A holding register |
| code_b_o | output | CODE_W | Channel B holding register |

## Verification
The bench builds the block with CODE_W = 12 and SYNC_STAGES = 3. The deeper sampler puts one more edge between a pin change and its effect, so the latency requirement is measured at a depth other than the default. The full-width frame exercises both bit-reversed fields with asymmetric codes, in which a swapped or mirrored field cannot go unnoticed. Held strobes, deselected frames and a mid-run clear are compared every cycle against a behavioural model of the sampling delay.

// File: rtl/dcl_pkg.sv
`timescale 1ns/1ps
package dcl_pkg;
  // bit positions of the sampled pin vector
  localparam int PIN_SCLK = 0;
  localparam int PIN_SDI  = 1;
  localparam int PIN_SEL  = 2;
  localparam int PIN_UPA  = 3;
  localparam int PIN_UPB  = 4;
  localparam int NUM_PINS = 5;

  typedef struct packed {
    logic shift;
    logic load_a;
    logic load_b;
  } dcl_cmd_t;
endpackage

// File: rtl/dcl_sync.sv
`timescale 1ns/1ps
module dcl_sync #(
  parameter int WIDTH  = 5,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             clr_n,
  input  logic [WIDTH-1:0] pin_i,
  output logic [WIDTH-1:0] level_o,
  output logic [WIDTH-1:0] fall_o
);
  logic [STAGES-1:0][WIDTH-1:0] chain_q;
  logic [WIDTH-1:0]             prev_q;

  // zero reset: a pin held low across clear can never produce a fall
  always_ff @(posedge clk or negedge clr_n) begin
    if (!clr_n) begin
      chain_q <= '0;
      prev_q  <= '0;
    end else begin
      chain_q <= {chain_q[STAGES-2:0], pin_i};
      prev_q  <= chain_q[STAGES-1];
    end
  end

  assign level_o = chain_q[STAGES-1];

  for (genvar b = 0; b < WIDTH; b++) begin : g_edge
    assign fall_o[b] = prev_q[b] & ~chain_q[STAGES-1][b];
  end

  // a detected fall lasts exactly one cycle (R9 edge timing)
  p_fall_single_r9: assert property (@(posedge clk) disable iff (!clr_n)
    (fall_o != '0) |=> ((fall_o & $past(fall_o)) == '0));
endmodule

// File: rtl/dcl_shifter.sv
`timescale 1ns/1ps
module dcl_shifter #(
  parameter int FRAME_W = 24
) (
  input  logic               clk,
  input  logic               clr_n,
  input  logic               shift_i,
  input  logic               bit_i,
  output logic [FRAME_W-1:0] frame_o
);
  always_ff @(posedge clk or negedge clr_n) begin
    if (!clr_n)       frame_o <= '0;
    else if (shift_i) frame_o <= {bit_i, frame_o[FRAME_W-1:1]};
  end

  p_hold_r2: assert property (@(posedge clk) disable iff (!clr_n)
    !shift_i |=> $stable(frame_o));
  p_entry_r3: assert property (@(posedge clk) disable iff (!clr_n)
    shift_i |=> (frame_o[FRAME_W-1] == $past(bit_i)));
  p_move_r3: assert property (@(posedge clk) disable iff (!clr_n)
    shift_i |=> (frame_o[FRAME_W-2:0] == $past(frame_o[FRAME_W-1:1])));
endmodule

// File: rtl/dcl_hold.sv
`timescale 1ns/1ps
module dcl_hold #(
  parameter int CODE_W = 12
) (
  input  logic                  clk,
  input  logic                  clr_n,
  input  logic [2*CODE_W-1:0]   frame_i,
  input  logic                  load_a_i,
  input  logic                  load_b_i,
  output logic [CODE_W-1:0]     code_a_o,
  output logic [CODE_W-1:0]     code_b_o
);
  localparam int NUM_CH = 2;
  logic [NUM_CH-1:0] load;
  assign load = {load_a_i, load_b_i};   // index 1 = A (upper field), 0 = B

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    logic [CODE_W-1:0] fld;
    logic [CODE_W-1:0] q;
    // field MSB sits at the low end of its half of the frame
    always_comb begin
      for (int i = 0; i < CODE_W; i++) fld[i] = frame_i[(c+1)*CODE_W-1-i];
    end
    always_ff @(posedge clk or negedge clr_n) begin
      if (!clr_n)       q <= '0;
      else if (load[c]) q <= fld;
    end
  end

  assign code_a_o = g_ch[1].q;
  assign code_b_o = g_ch[0].q;

  p_keep_a_r4: assert property (@(posedge clk) disable iff (!clr_n)
    !load_a_i |=> $stable(code_a_o));
  p_msb_a_r4: assert property (@(posedge clk) disable iff (!clr_n)
    load_a_i |=> (code_a_o[CODE_W-1] == $past(frame_i[CODE_W])));
  p_keep_b_r5: assert property (@(posedge clk) disable iff (!clr_n)
    !load_b_i |=> $stable(code_b_o));
  p_msb_b_r5: assert property (@(posedge clk) disable iff (!clr_n)
    load_b_i |=> (code_b_o[CODE_W-1] == $past(frame_i[0])));
endmodule

// File: rtl/dual_code_loader.sv
`timescale 1ns/1ps
module dual_code_loader
  import dcl_pkg::*;
#(
  parameter int CODE_W      = 12,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              clr_n,
  input  logic              sclk_i,
  input  logic              sdi_i,
  input  logic              sel_n_i,
  input  logic              upd_a_n_i,
  input  logic              upd_b_n_i,
  output logic [CODE_W-1:0] code_a_o,
  output logic [CODE_W-1:0] code_b_o
);
  localparam int FRAME_W = 2 * CODE_W;

  logic [NUM_PINS-1:0] pins, lvl, fall;
  logic [FRAME_W-1:0]  frame;
  dcl_cmd_t            cmd;
  logic                unused_pins;

  always_comb begin
    pins           = '0;
    pins[PIN_SCLK] = sclk_i;
    pins[PIN_SDI]  = sdi_i;
    pins[PIN_SEL]  = sel_n_i;
    pins[PIN_UPA]  = upd_a_n_i;
    pins[PIN_UPB]  = upd_b_n_i;
  end

  dcl_sync #(.WIDTH(NUM_PINS), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .clr_n(clr_n), .pin_i(pins), .level_o(lvl), .fall_o(fall)
  );

  // decode of the sampled pin levels and edges
  always_comb begin
    cmd.shift  = fall[PIN_SCLK] & ~lvl[PIN_SEL] & lvl[PIN_UPA] & lvl[PIN_UPB];
    cmd.load_a = fall[PIN_UPA]  & ~lvl[PIN_SEL];
    cmd.load_b = fall[PIN_UPB]  & ~lvl[PIN_SEL];
  end

  assign unused_pins = ^{fall[PIN_SDI], fall[PIN_SEL], lvl[PIN_SCLK]};

  dcl_shifter #(.FRAME_W(FRAME_W)) u_shift (
    .clk(clk), .clr_n(clr_n), .shift_i(cmd.shift), .bit_i(lvl[PIN_SDI]),
    .frame_o(frame)
  );

  dcl_hold #(.CODE_W(CODE_W)) u_hold (
    .clk(clk), .clr_n(clr_n), .frame_i(frame),
    .load_a_i(cmd.load_a), .load_b_i(cmd.load_b),
    .code_a_o(code_a_o), .code_b_o(code_b_o)
  );

  p_desel_r7: assert property (@(posedge clk) disable iff (!clr_n)
    lvl[PIN_SEL] |=> ($stable(code_a_o) && $stable(code_b_o) && $stable(frame)));
endmodule

// File: tb/dual_code_loader_tb.sv
`timescale 1ns/1ps
module dual_code_loader_tb;
  localparam int CW = 12;
  localparam int ST = 3;
  localparam int FW = 2 * CW;

  logic clk = 0, clr_n = 0, sclk = 1, sdi = 0, sel_n = 1, upa_n = 1, upb_n = 1;
  logic [CW-1:0] code_a, code_b;
  int n_chk = 0, n_bad = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  dual_code_loader #(.CODE_W(CW), .SYNC_STAGES(ST)) u_dut (
    .clk(clk), .clr_n(clr_n), .sclk_i(sclk), .sdi_i(sdi), .sel_n_i(sel_n),
    .upd_a_n_i(upa_n), .upd_b_n_i(upb_n), .code_a_o(code_a), .code_b_o(code_b)
  );

  task automatic check(string tag, logic [CW-1:0] act, logic [CW-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic finish_up();
    if (!done) begin
      done = 1;
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  endtask

  // behavioural reference: history of sampled pins {upb,upa,sel,sdi,sclk}
  logic [4:0]    smp [0:ST] = '{default: '0};
  logic [4:0]    cur = '0, old = '0;
  logic [FW-1:0] m_sr = '0;
  logic [CW-1:0] m_a = '0, m_b = '0;

  always @(posedge clk or negedge clr_n) begin
    if (!clr_n) begin
      m_sr = '0; m_a = '0; m_b = '0;
      for (int k = 0; k <= ST; k++) smp[k] = '0;
    end else begin
      cur = smp[ST-1];
      old = smp[ST];
      if (old[0] && !cur[0] && !cur[2] && cur[3] && cur[4])
        m_sr = {cur[1], m_sr[FW-1:1]};
      else begin
        if (old[3] && !cur[3] && !cur[2])
          for (int i = 0; i < CW; i++) m_a[i] = m_sr[FW-1-i];
        if (old[4] && !cur[4] && !cur[2])
          for (int i = 0; i < CW; i++) m_b[i] = m_sr[CW-1-i];
      end
      for (int k = ST; k > 0; k--) smp[k] = smp[k-1];
      smp[0] = {upb_n, upa_n, sel_n, sdi, sclk};
    end
  end

  always @(posedge clk) begin
    #2;
    if (!done) begin
      check("model A (R3 R4 R6 R9)", code_a, m_a);
      check("model B (R3 R5 R6 R9)", code_b, m_b);
    end
  end

  task automatic cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic send_bit(logic b);
    sdi = b; sclk = 0; cyc(ST + 2);
    sclk = 1; cyc(ST + 2);
  endtask

  task automatic send_frame(logic [CW-1:0] a, logic [CW-1:0] b);
    logic [FW-1:0] w;
    w = {b, a};
    for (int i = FW - 1; i >= 0; i--) send_bit(w[i]);
  endtask

  task automatic strobe(bit da, bit db);
    if (da) upa_n = 0;
    if (db) upb_n = 0;
    cyc(ST + 3);
    upa_n = 1; upb_n = 1;
    cyc(ST + 3);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog R9 actual=hung expected=finished");
      finish_up();
    end
  end

  initial begin
    cyc(3);
    check("R1 reset A", code_a, '0);
    check("R1 reset B", code_b, '0);
    clr_n = 1; cyc(ST + 2);
    sel_n = 0; cyc(ST + 2);

    // R3/R4: A only
    send_frame(12'hA53, 12'h3C6);
    strobe(1, 0);
    check("R4 load A", code_a, 12'hA53);
    check("R4 B untouched", code_b, 12'h000);
    // R5: B only
    strobe(0, 1);
    check("R5 load B", code_b, 12'h3C6);
    check("R5 A untouched", code_a, 12'hA53);

    // R6: both together, R3 extreme bits
    send_frame(12'h001, 12'h800);
    strobe(1, 1);
    check("R6 R3 both A", code_a, 12'h001);
    check("R6 R3 both B", code_b, 12'h800);

    // R9: latency of an A strobe
    send_frame(12'hFFF, 12'h123);
    upa_n = 0;
    repeat (ST) @(posedge clk);
    @(negedge clk);
    check("R9 not yet loaded", code_a, 12'h001);
    @(negedge clk);
    check("R9 loaded on time", code_a, 12'hFFF);
    upa_n = 1; cyc(ST + 3);

    // R2: serial edges while a strobe is low do not shift
    upa_n = 0; cyc(ST + 3);
    for (int t = 0; t < 3; t++) begin
      sdi = 0; sclk = 0; cyc(ST + 2);
      sclk = 1; cyc(ST + 2);
    end
    upa_n = 1; cyc(ST + 3);
    strobe(1, 1);
    check("R2 no shift A", code_a, 12'hFFF);
    check("R2 no shift B", code_b, 12'h123);

    // R7: deselected frame and strobes do nothing
    sel_n = 1; cyc(ST + 2);
    send_frame(12'h111, 12'h222);
    strobe(1, 1);
    check("R7 desel A", code_a, 12'hFFF);
    check("R7 desel B", code_b, 12'h123);
    sel_n = 0; cyc(ST + 2);
    strobe(1, 1);
    check("R7 frame kept A", code_a, 12'hFFF);
    check("R7 frame kept B", code_b, 12'h123);

    // R8: strobe fallen while deselected does not load later
    send_frame(12'h5A5, 12'h0F0);
    sel_n = 1; cyc(ST + 2);
    upa_n = 0; cyc(ST + 2);
    sel_n = 0; cyc(ST + 3);
    check("R8 no late load", code_a, 12'hFFF);
    upa_n = 1; cyc(ST + 3);
    strobe(1, 0);
    check("R8 fresh edge loads", code_a, 12'h5A5);
    check("R8 B untouched", code_b, 12'h123);

    // R1: asynchronous clear, frame register emptied too
    upb_n = 0;
    clr_n = 0;
    #1;
    check("R1 async A", code_a, '0);
    check("R1 async B", code_b, '0);
    cyc(2);
    upb_n = 1;
    clr_n = 1; cyc(ST + 2);
    strobe(1, 1);
    check("R1 frame cleared A", code_a, '0);
    check("R1 frame cleared B", code_b, '0);

    cyc(4);
    finish_up();
  end
endmodule